// File: doc/BRIEF.md
# Three-Channel Down-Counter Timer with Watchdog Reset

The block holds three 32-bit down-counters that step once per clock. Channel 0 is the event timer. Software loads a first interval into its count register and a period into its reload register, then picks periodic or single-shot behaviour with an auto-reload bit. Channel 1 is meant to run free as a reference count that software reads back. Channel 2 is the watchdog. When it expires it can pull a sticky reset request high, but only if a separate reset-enable bit allows it.

Each expiry sets a bit in a shared cause register. A mask register picks which cause bits reach the level interrupt output. Software clears a cause bit by writing zero to it. A simple bus with one-cycle writes and a combinational read reaches every register. Byte offsets are: count of channel n at 8·n, reload of channel n at 8·n+4, control at 0x18, cause at 0x1C, mask at 0x20, reset-enable at 0x24.

Top module: `tmr_wdog_top`

## Requirements
- R1: After reset all count and reload registers read 0xFFFFFFFF. Control, cause, mask and reset-enable read 0. `irq_o` and `wdog_rst_o` are low.
- R2: An enabled channel whose count is non-zero goes down by exactly one on each clock. The count of channel n is at byte offset 8·n and its reload at 8·n+4.
- R3: The control register at 0x18 holds bit 2n as the enable of channel n and bit 2n+1 as its auto-reload. It reads back what was written. Bits above bit 5 read zero.
- R4: With enable and auto-reload set, a channel that has reached zero loads its reload value on the next clock and counts on. After the first expiry, the period is reload+1 clocks.
- R5: With auto-reload clear, a channel that reaches zero stays at zero and raises no further expiry.
- R6: Cause bit n (register 0x1C) is set on the clock where channel n goes from 1 to 0. Writing 0 to a cause bit clears it and writing 1 leaves it unchanged. If an expiry and a clearing write hit the same clock, the bit stays set.
- R7: `irq_o` is high exactly when some cause bit and the matching bit of the mask register (0x20) are both set.
- R8: A channel whose enable bit is clear keeps its count unchanged and raises no expiry.
- R9: `wdog_rst_o` goes high after a channel 2 expiry only if bit 0 of the reset-enable register (0x24) is set. Once high, it stays high until block reset.
- R10: A bus write to a count register takes priority over that channel's decrement or reload in the same clock. That clock then produces no expiry.
- R11: Reads return the current register value combinationally. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; counters step on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high together with bus_sel_i |
| bus_addr_i | input | 6 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Level interrupt, OR of cause AND mask |
| wdog_rst_o | output | 1 | Sticky watchdog reset request |

## Verification
The main check sweeps every combination of first interval 1 to 4 and reload 0 to 3 in periodic mode. It follows the count and the cause bit on every clock, so an off-by-one in the reload period, a missed reload of zero, or a cause bit set at the wrong clock shows up as a value mismatch. A full sweep of all eight mask values over a fixed cause pattern checks the interrupt gating. Single-shot runs, frozen channels and count writes timed onto the very clock of an expiry separate the stop, freeze and priority rules. Two watchdog runs, one with the reset enable clear and one with it set, show both the gating and the stickiness of the reset output.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CH_STRIDE   = 8;
  localparam int RLD_OFFSET  = 4;
  localparam int OFS_CTRL    = 'h18;
  localparam int OFS_CAUSE   = 'h1C;
  localparam int OFS_MASK    = 'h20;
  localparam int OFS_RSTEN   = 'h24;
  localparam int BITS_PER_CH = 2;

  function automatic int cnt_ofs(input int ch);
    return ch * CH_STRIDE;
  endfunction

  function automatic int rld_ofs(input int ch);
    return ch * CH_STRIDE + RLD_OFFSET;
  endfunction
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             auto_i,
  input  logic             cnt_we_i,
  input  logic             rld_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;
  logic             cnt_ce, expire;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (cnt_we_i) begin
      cnt_d = wdata_i;
    end else if (en_i) begin
      if (cnt_q != '0) begin
        cnt_d  = cnt_q - ONE;
        expire = (cnt_q == ONE);
      end else if (auto_i) begin
        cnt_d = rld_q;
      end
    end
  end

  assign rld_d  = wdata_i;
  assign cnt_ce = cnt_we_i | en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '1;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rld_q <= '1;
    else if (rld_we_i) rld_q <= rld_d;
  end

  assign cnt_o    = cnt_q;
  assign rld_o    = rld_q;
  assign expire_o = expire;

  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !cnt_we_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE)); // R2
  AST_AUTO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && auto_i && !cnt_we_i && cnt_q == '0) |=> (cnt_q == $past(rld_q))); // R4
  AST_ONESHOT_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !auto_i && !cnt_we_i && cnt_q == '0) |=> (cnt_q == '0)); // R5
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_we_i) |=> $stable(cnt_q)); // R8
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_q == $past(wdata_i))); // R10
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int NUM_CH = 3,
  parameter int WD_IDX = NUM_CH - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              cause_we_i,
  input  logic              mask_we_i,
  input  logic              rsten_we_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] cause_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic              rsten_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [NUM_CH-1:0] cause_q, cause_d, mask_q;
  logic              rsten_q, rst_q, rst_d;

  always_comb begin
    cause_d = cause_q;
    if (cause_we_i) cause_d = cause_q & wdata_i;
    cause_d = cause_d | evt_i;
    rst_d   = rst_q | (evt_i[WD_IDX] & rsten_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      rst_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      rst_q   <= rst_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rsten_q <= 1'b0;
    else if (rsten_we_i) rsten_q <= wdata_i[0];
  end

  assign cause_o   = cause_q;
  assign mask_o    = mask_q;
  assign rsten_o   = rsten_q;
  assign irq_o     = |(cause_q & mask_q);
  assign rst_req_o = rst_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> cause_q[g]); // R6
    AST_CLEAR_BY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cause_q[g]) |-> $past(cause_we_i && !wdata_i[g])); // R6
  end

  AST_RST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> rst_q); // R9
  AST_RST_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> $past(evt_i[WD_IDX] && rsten_q)); // R9
endmodule

// File: rtl/tmr_wdog_top.sv
module tmr_wdog_top #(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic              wdog_rst_o
);
  import tmr_pkg::*;

  localparam int CTRL_W = BITS_PER_CH * NUM_CH;
  localparam int WD_IDX = NUM_CH - 1;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_RSTEN = ADDR_W'(OFS_RSTEN);

  logic              rst_n;
  logic              wr;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_ce;
  logic [NUM_CH-1:0] cnt_we, rld_we, expire;
  logic [CNT_W-1:0]  cnt_v [NUM_CH];
  logic [CNT_W-1:0]  rld_v [NUM_CH];
  logic [NUM_CH-1:0] cause, mask;
  logic              rsten;

  tmr_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  assign wr      = bus_sel_i & bus_we_i;
  assign ctrl_ce = wr & (bus_addr_i == A_CTRL);
  assign ctrl_d  = bus_wdata_i[CTRL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ce) ctrl_q <= ctrl_d;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(cnt_ofs(g));
    localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(rld_ofs(g));

    assign cnt_we[g] = wr & (bus_addr_i == A_CNT);
    assign rld_we[g] = wr & (bus_addr_i == A_RLD);

    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_n),
      .en_i     (ctrl_q[BITS_PER_CH*g]),
      .auto_i   (ctrl_q[BITS_PER_CH*g+1]),
      .cnt_we_i (cnt_we[g]),
      .rld_we_i (rld_we[g]),
      .wdata_i  (bus_wdata_i),
      .cnt_o    (cnt_v[g]),
      .rld_o    (rld_v[g]),
      .expire_o (expire[g])
    );
  end

  tmr_irq #(.NUM_CH(NUM_CH), .WD_IDX(WD_IDX)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .evt_i      (expire),
    .cause_we_i (wr & (bus_addr_i == A_CAUSE)),
    .mask_we_i  (wr & (bus_addr_i == A_MASK)),
    .rsten_we_i (wr & (bus_addr_i == A_RSTEN)),
    .wdata_i    (bus_wdata_i[NUM_CH-1:0]),
    .cause_o    (cause),
    .mask_o     (mask),
    .rsten_o    (rsten),
    .irq_o      (irq_o),
    .rst_req_o  (wdog_rst_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr_i == ADDR_W'(cnt_ofs(i))) bus_rdata_o = cnt_v[i];
      if (bus_addr_i == ADDR_W'(rld_ofs(i))) bus_rdata_o = rld_v[i];
    end
    if (bus_addr_i == A_CTRL)  bus_rdata_o[CTRL_W-1:0] = ctrl_q;
    if (bus_addr_i == A_CAUSE) bus_rdata_o[NUM_CH-1:0] = cause;
    if (bus_addr_i == A_MASK)  bus_rdata_o[NUM_CH-1:0] = mask;
    if (bus_addr_i == A_RSTEN) bus_rdata_o[0]          = rsten;
  end

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ctrl_ce |=> $stable(ctrl_q)); // R3
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mask == '0) |-> !irq_o); // R7
endmodule

// File: tb/tmr_wdog_top_tb_top.sv
module tmr_wdog_top_tb_top;
  localparam logic [5:0] A_CNT0 = 6'h00, A_RLD0 = 6'h04, A_CNT1 = 6'h08,
                         A_RLD1 = 6'h0C, A_CNT2 = 6'h10, A_RLD2 = 6'h14,
                         A_CTRL = 6'h18, A_CAUSE = 6'h1C, A_MASK = 6'h20,
                         A_RSTEN = 6'h24;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        bus_sel, bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, wrst;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  tmr_wdog_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel),
    .bus_we_i    (bus_we),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .irq_o       (irq),
    .wdog_rst_o  (wrst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    step(4);
    rst_ni = 1'b1;
    step(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout act=0 exp=1");
    finish_run();
  end

  initial begin
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    @(negedge clk);
    do_reset();

    // R1 reset values
    begin
      logic [5:0] ones [6];
      ones = '{A_CNT0, A_RLD0, A_CNT1, A_RLD1, A_CNT2, A_RLD2};
      for (int i = 0; i < 6; i++) begin rd(ones[i], v); check("R1 count/reload", v, 32'hFFFF_FFFF); end
    end
    rd(A_CTRL, v);  check("R1 ctrl", v, 0);
    rd(A_CAUSE, v); check("R1 cause", v, 0);
    rd(A_MASK, v);  check("R1 mask", v, 0);
    rd(A_RSTEN, v); check("R1 rsten", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 wdog reset", {31'b0, wrst}, 0);

    // R3 control readback, R11 unmapped
    wr(A_CTRL, 32'hFFFF_FFEA);
    rd(A_CTRL, v); check("R3 ctrl readback", v, 32'h2A);
    wr(A_CTRL, 0);
    rd(6'h28, v); check("R11 unmapped", v, 0);
    rd(6'h3C, v); check("R11 unmapped", v, 0);
    wr(A_RLD1, 32'h1234_5678);
    rd(A_RLD1, v); check("R11 reload readback", v, 32'h1234_5678);

    // R2 R4 R6 periodic sweep: first interval n, reload r
    for (int n = 1; n <= 4; n++) begin
      for (int r = 0; r <= 3; r++) begin
        int e;
        logic seen;
        wr(A_CTRL, 0);
        wr(A_CAUSE, 0);
        wr(A_RLD0, r);
        wr(A_CNT0, n);
        wr(A_CTRL, 32'h3);
        e = n; seen = 1'b0;
        for (int k = 0; k < 12; k++) begin
          step(1);
          if (e != 0) begin
            if (e == 1) seen = 1'b1;
            e = e - 1;
          end else begin
            e = r;
          end
          rd(A_CNT0, v);  check("R2/R4 periodic count", v, e);
          rd(A_CAUSE, v); check("R6 periodic cause", v, {31'b0, seen});
        end
      end
    end

    // R5 single shot
    wr(A_CTRL, 0); wr(A_CAUSE, 0);
    wr(A_CNT0, 3);
    wr(A_CTRL, 32'h1);
    step(3);
    rd(A_CNT0, v);  check("R5 reached zero", v, 0);
    rd(A_CAUSE, v); check("R5 one expiry", v, 1);
    step(5);
    rd(A_CNT0, v);  check("R5 parked at zero", v, 0);
    wr(A_CAUSE, 0);
    step(5);
    rd(A_CAUSE, v); check("R5 no second expiry", v, 0);

    // R8 freeze
    wr(A_CTRL, 0); wr(A_CAUSE, 0);
    wr(A_CNT1, 10);
    wr(A_CTRL, 32'h4);
    step(3);
    wr(A_CTRL, 0);
    rd(A_CNT1, v); check("R8 frozen value", v, 6);
    step(5);
    rd(A_CNT1, v); check("R8 stays frozen", v, 6);
    wr(A_CNT1, 1);
    step(4);
    rd(A_CAUSE, v); check("R8 disabled no expiry", v, 0);
    rd(A_CNT1, v);  check("R8 disabled count kept", v, 1);

    // R10 write priority
    wr(A_CNT0, 50);
    wr(A_CTRL, 32'h1);
    wr(A_CNT0, 100);
    rd(A_CNT0, v); check("R10 write beats decrement", v, 100);
    wr(A_CTRL, 0); wr(A_CAUSE, 0);
    wr(A_CNT0, 3);
    wr(A_CTRL, 32'h1);
    step(2);
    rd(A_CNT0, v); check("R2 count at one", v, 1);
    wr(A_CNT0, 7);
    rd(A_CNT0, v);  check("R10 write at expiry clock", v, 7);
    rd(A_CAUSE, v); check("R10 expiry suppressed", v, 0);

    // R6 set wins over clearing write, bit without event clears
    wr(A_CTRL, 0); wr(A_CAUSE, 0);
    wr(A_CNT0, 2);
    wr(A_CNT1, 1);
    wr(A_CTRL, 32'h5);
    step(1);
    wr(A_CAUSE, 0);
    rd(A_CAUSE, v); check("R6 set wins, other cleared", v, 1);

    // R7 mask sweep over cause = 111, R6 write-one keeps
    wr(A_CTRL, 0); wr(A_CAUSE, 0);
    wr(A_CNT0, 1); wr(A_CNT1, 1); wr(A_CNT2, 1);
    wr(A_CTRL, 32'h15);
    step(2);
    rd(A_CAUSE, v); check("R6 all three set", v, 7);
    for (int m = 0; m < 8; m++) begin
      wr(A_MASK, m);
      check("R7 irq vs mask", {31'b0, irq}, {31'b0, (m != 0)});
    end
    check("R9 no reset without enable", {31'b0, wrst}, 0);
    wr(A_CAUSE, 32'h5);
    rd(A_CAUSE, v); check("R6 write one keeps", v, 5);
    wr(A_MASK, 32'h2);
    check("R7 masked off", {31'b0, irq}, 0);
    wr(A_MASK, 32'h4);
    check("R7 bit2 passes", {31'b0, irq}, 1);
    wr(A_CAUSE, 0);
    check("R7 cleared cause drops irq", {31'b0, irq}, 0);

    // R9 watchdog reset with enable
    wr(A_CTRL, 0);
    wr(A_RSTEN, 1);
    wr(A_CNT2, 2);
    wr(A_CTRL, 32'h10);
    step(1);
    check("R9 not yet", {31'b0, wrst}, 0);
    step(2);
    check("R9 reset raised", {31'b0, wrst}, 1);
    rd(A_CAUSE, v); check("R9 watchdog cause", v, 4);
    wr(A_CTRL, 0); wr(A_CAUSE, 0); wr(A_RSTEN, 0);
    step(3);
    check("R9 reset sticky", {31'b0, wrst}, 1);
    do_reset();
    check("R1 reset clears wdog reset", {31'b0, wrst}, 0);
    rd(A_CNT2, v); check("R1 count after reset", v, 32'hFFFF_FFFF);

    finish_run();
  end
endmodule